// File: doc/BRIEF.md
# Clock/Control Register Space Address Sequencer

This block sits behind a serial slave front end and steers register addresses for a 64-location clock/control space. The space holds five fixed regions. Two are 8-byte alarm blocks at 0x00 and 0x08. A single control byte sits at 0x10. The 8-byte clock counters sit at 0x30 to 0x37, and a single status byte sits at 0x3F. Every other address is unused. The front end passes the device-select byte of each transfer, the start address of a write transfer, a strobe for every data byte moved, and a stop indication. The block keeps the current address and advances it after each byte. It reports whether the location exists and whether a write there is allowed. It ends a transfer that overruns the status byte and announces when a completed write may be committed to storage.

Writes to every region except status are guarded by a two-step unlock. The unlock is driven by bytes written to the status location. Bit 1 is the write-enable bit and bit 2 is the register-write-enable bit. Register storage and the bus physical layer sit outside this block.

All inputs are single-cycle pulses sampled on the rising clock edge. The block accepts every pulse in the cycle it is presented and never applies back-pressure, so the front end needs no ready signal. When several pulses arrive in one cycle, a select has priority over stop, stop has priority over an address load, and an address load has priority over a byte strobe.

Top module: `ccr_addr_seq`

## Requirements
- R1: A select byte whose upper seven bits are 1101111 opens a transfer, with bit 0 = 1 for read and 0 for write. Any other select byte leaves the block idle, and address loads and byte strobes then change nothing.
- R2: An address load during an open write transfer sets `cur_addr` to `addr_in` on the next cycle. Address loads at other times are ignored.
- R3: Each accepted byte advances `cur_addr` by one inside its region. The last byte of a region wraps to that region's first byte: 0x07 to 0x00, 0x0F to 0x08 and 0x37 to 0x30. The control byte 0x10 stays at 0x10.
- R4: After one byte has been moved at the status address 0x3F, the next strobe in the same transfer raises `term`. `cur_addr` then holds 0x3F and later strobes have no effect. `term` clears on stop or on a new select.
- R5: The address is kept across stop and select, so a read that names no address continues from the location after the last one accessed.
- R6: Addresses outside the five regions give `in_map` = 0 and never allow a write. A strobe there advances the address by plain increment.
- R7: A status write committed with value 0x02 sets `wel` = 1 and `rwel` = 0. Value 0x06 committed while `wel` = 1 sets both bits. Any other committed status value, or 0x06 while `wel` = 0, clears both bits.
- R8: `wr_allow` is 1 only during an open write transfer that has not been terminated, at an in-map address, and only if that address is the status byte or `wel` = 1.
- R9: `commit` pulses in the cycle after a stop if that stop ends a write transfer which accepted at least one allowed byte, was not terminated, and either wrote the status byte or saw `rwel` = 1. A transfer cut short by a new select never commits.
- R10: While reset is held, `cur_addr` = 0 and `in_map` = 1. `term`, `wr_allow`, `commit`, `wel` and `rwel` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_valid | input | 1 | Device-select byte present this cycle |
| sel_byte | input | 8 | Device-select byte; bit 0 selects read |
| addr_load | input | 1 | Start address present this cycle |
| addr_in | input | 6 | Start address |
| byte_stb | input | 1 | One data byte moved at `cur_addr` |
| wr_byte | input | 8 | Data byte of a write strobe |
| stop | input | 1 | Transfer ended by a stop condition |
| cur_addr | output | 6 | Current register address |
| in_map | output | 1 | `cur_addr` lies inside a region |
| term | output | 1 | Transfer terminated by status overrun |
| wr_allow | output | 1 | A write byte at `cur_addr` is permitted |
| commit | output | 1 | Pulse: buffered write may be stored |
| wel | output | 1 | Write-enable bit |
| rwel | output | 1 | Register-write-enable bit |

## Verification
The bench targets the region wraps at 0x07, 0x0F, 0x10 and 0x37. A design that wrapped across the whole space would walk into the next region instead of returning to the region's first byte. A second strobe on the status byte must raise `term` and freeze the address. A design that treated status like control would loop silently and still commit. The unlock order is exercised in both directions, including 0x06 sent while locked: a design that accepted it would open the space in one step. Transfers cut off by a repeated select are also exercised, because a design that kept its write flag across a select would commit data that the bus aborted.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
  localparam logic [6:0] DEV_CODE = 7'b1101111;
  localparam int NSEC = 5;

  typedef enum logic [2:0] {SEC_AL0, SEC_AL1, SEC_CTL, SEC_CLK, SEC_STS, SEC_GAP} sec_e;
  typedef enum logic [1:0] {UL_LOCKED, UL_WEL, UL_OPEN} ul_e;

  localparam logic [7:0] UL_STEP1 = 8'h02;
  localparam logic [7:0] UL_STEP2 = 8'h06;

  function automatic int base_of(int i);
    case (i)
      0: return 0;
      1: return 8;
      2: return 16;
      3: return 48;
      default: return 63;
    endcase
  endfunction

  function automatic int size_of(int i);
    case (i)
      0, 1, 3: return 8;
      default: return 1;
    endcase
  endfunction
endpackage

// File: rtl/ccr_sec_decode.sv
module ccr_sec_decode
  import ccr_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic [ADDR_W-1:0] addr,
  output sec_e              sec,
  output logic [ADDR_W-1:0] nxt
);
  logic [NSEC-1:0] hit;
  logic [NSEC-1:0] at_end;

  for (genvar i = 0; i < NSEC; i++) begin : g_sec
    localparam int B = base_of(i);
    localparam int L = base_of(i) + size_of(i) - 1;
    assign hit[i]    = (int'(addr) >= B) && (int'(addr) <= L);
    assign at_end[i] = (int'(addr) == L);
  end

  always_comb begin
    sec = SEC_GAP;
    nxt = addr + ADDR_W'(1);
    for (int i = 0; i < NSEC; i++) begin
      if (hit[i]) begin
        sec = sec_e'(i[2:0]);
        nxt = at_end[i] ? ADDR_W'(base_of(i)) : addr + ADDR_W'(1);
      end
    end
  end
endmodule

// File: rtl/ccr_unlock.sv
module ccr_unlock
  import ccr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       apply,
  input  logic [7:0] val,
  output logic       wel,
  output logic       rwel
);
  ul_e st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= UL_LOCKED;
    end else if (apply) begin
      if (val == UL_STEP1)                         st <= UL_WEL;
      else if (val == UL_STEP2 && st != UL_LOCKED) st <= UL_OPEN;
      else                                         st <= UL_LOCKED;
    end
  end

  assign wel  = (st != UL_LOCKED);
  assign rwel = (st == UL_OPEN);

  AST_RWEL_IMPLIES_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    rwel |-> wel); // R7
  AST_OPEN_NEEDS_STEP1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rwel) |-> $past(wel)); // R7
endmodule

// File: rtl/ccr_addr_ptr.sv
module ccr_addr_ptr
  import ccr_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_valid,
  input  logic [7:0]        sel_byte,
  input  logic              addr_load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              byte_stb,
  input  logic [7:0]        wr_byte,
  input  logic              stop,
  input  logic              wel,
  input  logic              rwel,
  output logic [ADDR_W-1:0] ptr,
  output logic              in_map,
  output logic              term,
  output logic              wr_allow,
  output logic              commit_now,
  output logic              stat_apply,
  output logic [7:0]        stat_val
);
  logic              active, is_rd, wrote, stat_done;
  sec_e              sec;
  logic [ADDR_W-1:0] nxt;
  logic              wr_xfer, do_load, take_stb, overrun, adv;

  ccr_sec_decode #(.ADDR_W(ADDR_W)) u_dec (.addr(ptr), .sec(sec), .nxt(nxt));

  assign in_map   = (sec != SEC_GAP);
  assign wr_xfer  = active & ~is_rd;
  assign do_load  = ~sel_valid & ~stop & addr_load & wr_xfer;
  assign take_stb = ~sel_valid & ~stop & ~do_load & byte_stb & active & ~term;
  assign overrun  = (sec == SEC_STS) & stat_done;
  assign adv      = take_stb & ~overrun;
  assign wr_allow = wr_xfer & ~term & in_map & ((sec == SEC_STS) | wel);

  assign commit_now = stop & ~sel_valid & wr_xfer & wrote & ~term & (stat_done | rwel);
  assign stat_apply = commit_now & stat_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr       <= '0;
      active    <= 1'b0;
      is_rd     <= 1'b0;
      term      <= 1'b0;
      wrote     <= 1'b0;
      stat_done <= 1'b0;
      stat_val  <= '0;
    end else if (sel_valid) begin
      active    <= (sel_byte[7:1] == DEV_CODE);
      is_rd     <= sel_byte[0];
      term      <= 1'b0;
      wrote     <= 1'b0;
      stat_done <= 1'b0;
    end else if (stop) begin
      active    <= 1'b0;
      term      <= 1'b0;
      wrote     <= 1'b0;
      stat_done <= 1'b0;
    end else if (do_load) begin
      ptr       <= addr_in;
      wrote     <= 1'b0;
      stat_done <= 1'b0;
    end else if (take_stb) begin
      if (overrun) begin
        term <= 1'b1;
      end else begin
        ptr <= nxt;
        if (sec == SEC_STS) stat_done <= 1'b1;
        if (wr_allow) begin
          wrote <= 1'b1;
          if (sec == SEC_STS) stat_val <= wr_byte;
        end
      end
    end
  end

  AST_LOAD_TAKES_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    do_load |=> ptr == $past(addr_in)); // R2
  AST_WRAP_IN_REGION: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && sec != SEC_GAP) |=> sec == $past(sec)); // R3
  AST_TERM_AT_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    term |-> sec == SEC_STS); // R4
  AST_TERM_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    (term && !sel_valid) |=> $stable(ptr)); // R4
endmodule

// File: rtl/ccr_addr_seq.sv
module ccr_addr_seq
  import ccr_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_valid,
  input  logic [7:0]        sel_byte,
  input  logic              addr_load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              byte_stb,
  input  logic [7:0]        wr_byte,
  input  logic              stop,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              in_map,
  output logic              term,
  output logic              wr_allow,
  output logic              commit,
  output logic              wel,
  output logic              rwel
);
  logic       commit_now, stat_apply;
  logic [7:0] stat_val;

  ccr_addr_ptr #(.ADDR_W(ADDR_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .sel_valid(sel_valid), .sel_byte(sel_byte),
    .addr_load(addr_load), .addr_in(addr_in), .byte_stb(byte_stb),
    .wr_byte(wr_byte), .stop(stop), .wel(wel), .rwel(rwel),
    .ptr(cur_addr), .in_map(in_map), .term(term), .wr_allow(wr_allow),
    .commit_now(commit_now), .stat_apply(stat_apply), .stat_val(stat_val)
  );

  ccr_unlock u_unlock (
    .clk(clk), .rst_n(rst_n), .apply(stat_apply), .val(stat_val),
    .wel(wel), .rwel(rwel)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) commit <= 1'b0;
    else        commit <= commit_now;
  end

  AST_COMMIT_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> $past(stop)); // R9
  AST_NO_WRITE_OFF_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    !in_map |-> !wr_allow); // R6
endmodule

// File: tb/ccr_addr_seq_tb_top.sv
`timescale 1ns/1ps
module ccr_addr_seq_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel_valid = 1'b0, addr_load = 1'b0, byte_stb = 1'b0, stop = 1'b0;
  logic [7:0] sel_byte = '0, wr_byte = '0;
  logic [5:0] addr_in = '0;
  logic [5:0] cur_addr;
  logic       in_map, term, wr_allow, commit, wel, rwel;

  int errs = 0, checks = 0, cyc = 0;
  bit started = 0;

  always #2.5 clk = ~clk;

  ccr_addr_seq dut_i (
    .clk(clk), .rst_n(rst_n), .sel_valid(sel_valid), .sel_byte(sel_byte),
    .addr_load(addr_load), .addr_in(addr_in), .byte_stb(byte_stb),
    .wr_byte(wr_byte), .stop(stop), .cur_addr(cur_addr), .in_map(in_map),
    .term(term), .wr_allow(wr_allow), .commit(commit), .wel(wel), .rwel(rwel)
  );

  // behavioural reference
  int m_ptr, m_sval;
  bit m_act, m_rd, m_term, m_wrote, m_sdone, m_wel, m_rwel, m_commit;

  function automatic int region(int a);
    if (a < 8) return 0;
    if (a < 16) return 1;
    if (a == 16) return 2;
    if (a >= 48 && a < 56) return 3;
    if (a == 63) return 4;
    return 5;
  endfunction

  function automatic int step(int a);
    int r, b, s;
    r = region(a);
    if (r == 5) return (a + 1) % 64;
    b = (r == 0) ? 0 : (r == 1) ? 8 : (r == 2) ? 16 : (r == 3) ? 48 : 63;
    s = (r == 2 || r == 4) ? 1 : 8;
    return (a == b + s - 1) ? b : a + 1;
  endfunction

  always @(posedge clk) begin
    int r;
    bit ok;
    started <= 1;
    if (!rst_n) begin
      m_ptr = 0; m_sval = 0; m_act = 0; m_rd = 0; m_term = 0; m_wrote = 0;
      m_sdone = 0; m_wel = 0; m_rwel = 0; m_commit = 0;
    end else begin
      m_commit = 0;
      if (sel_valid) begin
        m_act = (sel_byte[7:1] == 7'b1101111); m_rd = sel_byte[0];
        m_term = 0; m_wrote = 0; m_sdone = 0;
      end else if (stop) begin
        if (m_act && !m_rd && m_wrote && !m_term && (m_sdone || m_rwel)) begin
          m_commit = 1;
          if (m_sdone) begin
            if (m_sval == 2) begin m_wel = 1; m_rwel = 0; end
            else if (m_sval == 6 && m_wel) begin m_wel = 1; m_rwel = 1; end
            else begin m_wel = 0; m_rwel = 0; end
          end
        end
        m_act = 0; m_term = 0; m_wrote = 0; m_sdone = 0;
      end else if (addr_load && m_act && !m_rd) begin
        m_ptr = addr_in; m_wrote = 0; m_sdone = 0;
      end else if (byte_stb && m_act && !m_term) begin
        r = region(m_ptr);
        if (r == 4 && m_sdone) m_term = 1;
        else begin
          ok = !m_rd && r != 5 && (r == 4 || m_wel);
          if (ok) begin m_wrote = 1; if (r == 4) m_sval = wr_byte; end
          if (r == 4) m_sdone = 1;
          m_ptr = step(m_ptr);
        end
      end
    end
  end

  task automatic cmp(string req, string nm, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, nm, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    bit exp_wa;
    if (started) begin
      exp_wa = m_act && !m_rd && !m_term && region(m_ptr) != 5 && (region(m_ptr) == 4 || m_wel);
      cmp("R3", "cur_addr", int'(cur_addr), m_ptr);
      cmp("R6", "in_map", int'(in_map), int'(region(m_ptr) != 5));
      cmp("R4", "term", int'(term), int'(m_term));
      cmp("R8", "wr_allow", int'(wr_allow), int'(exp_wa));
      cmp("R9", "commit", int'(commit), int'(m_commit));
      cmp("R7", "wel", int'(wel), int'(m_wel));
      cmp("R7", "rwel", int'(rwel), int'(m_rwel));
    end
  end

  task automatic do_sel(input logic [7:0] b);
    sel_valid = 1; sel_byte = b; @(negedge clk); sel_valid = 0;
  endtask
  task automatic do_load(input logic [5:0] a);
    addr_load = 1; addr_in = a; @(negedge clk); addr_load = 0;
  endtask
  task automatic do_stb(input logic [7:0] d);
    byte_stb = 1; wr_byte = d; @(negedge clk); byte_stb = 0;
  endtask
  task automatic do_stop();
    stop = 1; @(negedge clk); stop = 0;
  endtask
  task automatic wr_status(input logic [7:0] v);
    do_sel(8'hDE); do_load(6'h3F); do_stb(v); do_stop();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    cmp("R10", "reset cur_addr", int'(cur_addr), 0);
    cmp("R10", "reset wel", int'(wel), 0);
    rst_n = 1;
    @(negedge clk);
    // R7 unlock in two steps
    wr_status(8'h02);
    cmp("R7", "step1 wel", int'(wel), 1);
    cmp("R7", "step1 rwel", int'(rwel), 0);
    wr_status(8'h06);
    cmp("R7", "step2 rwel", int'(rwel), 1);
    // R3 wrap in alarm 0
    do_sel(8'hDE); do_load(6'h06);
    do_stb(8'hAA); do_stb(8'hAB); do_stb(8'hAC);
    cmp("R3", "alarm0 wrap", int'(cur_addr), 1);
    do_stop();
    cmp("R9", "commit after alarm write", int'(commit), 1);
    // R5 current-address read
    do_sel(8'hDF); do_stb(8'h00); do_stop();
    do_sel(8'hDF); do_stb(8'h00);
    cmp("R5", "continued read", int'(cur_addr), 3);
    do_stop();
    // R1 foreign select
    do_sel(8'hA1); do_stb(8'h00); do_load(6'h20);
    cmp("R1", "foreign select addr", int'(cur_addr), 3);
    cmp("R1", "foreign select wr_allow", int'(wr_allow), 0);
    // R2 and R6 gap
    do_sel(8'hDE); do_load(6'h2E);
    cmp("R2", "load addr", int'(cur_addr), 6'h2E);
    cmp("R6", "gap in_map", int'(in_map), 0);
    do_stb(8'h11); do_stb(8'h12);
    cmp("R6", "gap walk", int'(cur_addr), 6'h30);
    // R3 clock wrap
    do_load(6'h36); do_stb(8'h21); do_stb(8'h22);
    cmp("R3", "clock wrap", int'(cur_addr), 6'h30);
    do_stop();
    cmp("R9", "commit clock write", int'(commit), 1);
    // R4 status overrun
    do_sel(8'hDE); do_load(6'h3F); do_stb(8'h00); do_stb(8'h00);
    cmp("R4", "term raised", int'(term), 1);
    do_stb(8'h00);
    cmp("R4", "addr frozen", int'(cur_addr), 6'h3F);
    do_stop();
    cmp("R9", "no commit after term", int'(commit), 0);
    cmp("R4", "unlock kept", int'(rwel), 1);
    // R3 control self-wrap, R9 repeated select discards
    do_sel(8'hDE); do_load(6'h10); do_stb(8'h31); do_stb(8'h32);
    cmp("R3", "control wrap", int'(cur_addr), 6'h10);
    do_sel(8'hDE); do_stop();
    cmp("R9", "aborted write", int'(commit), 0);
    // R7 lock and bad order
    wr_status(8'h00);
    cmp("R7", "lock wel", int'(wel), 0);
    do_sel(8'hDE); do_load(6'h0F);
    cmp("R8", "locked wr_allow", int'(wr_allow), 0);
    do_stb(8'h41);
    cmp("R3", "alarm1 wrap", int'(cur_addr), 6'h08);
    do_stop();
    wr_status(8'h06);
    cmp("R7", "06 while locked", int'(wel), 0);
    wr_status(8'h02);
    do_sel(8'hDE); do_load(6'h09);
    cmp("R8", "wel wr_allow", int'(wr_allow), 1);
    do_stb(8'h51); do_stop();
    cmp("R9", "no commit without rwel", int'(commit), 0);
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errs++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule